// File: doc/BRIEF.md
# Dual-Window Host-to-PCI Address Translator

This block maps host bus accesses that land inside an 8 MB aperture onto PCI memory addresses. The aperture is cut into a lower and an upper 4 MB half. With dual-window mode on, each half is redirected through its own programmable 4 MB-aligned window base. With the mode off, the whole aperture runs through the primary base alone.

The host sets the bases with a 16-bit window register write that arrives with its two bytes exchanged. One bit of the corrected value chooses which base the write lands in. A readback word returns a fixed identity bit together with the current primary window value. Per access, the block outputs a hit, the index of the window used and the translated PCI address. The address path is combinational from the stored bases.

Top module: `pci_window_xlat`

## Requirements
- R1: The written word `reg_wdata_i` is byte-exchanged to form the logical value v = {wdata[7:0], wdata[15:8]}; every field below refers to v.
- R2: A window base is v AND 0xFFC0 shifted left by 16, so each base is a multiple of 4 MB.
- R3: With `dual_en_i` high and v bit 4 set, a write changes only the secondary base; the primary base and the readback stay unchanged.
- R4: With v bit 4 clear, a write changes only the primary base; the secondary base stays unchanged.
- R5: With `dual_en_i` low, v bit 4 is ignored: every write goes to the primary base, the secondary base is untouched, and every hit reports window index 0.
- R6: `hit_o` is high exactly when `acc_valid_i` is high and aperture_base ≤ address < aperture_base + 0x80_0000 (unsigned). Addresses below the base or at or above the end miss.
- R7: In dual mode, a hit with offset (address − aperture_base) ≥ 0x40_0000 reports index 1 and pci_addr = offset − 0x40_0000 + secondary base.
- R8: Any other hit reports index 0 and pci_addr = offset + primary base.
- R9: `reg_rdata_o` = 0x2000 OR byte-exchanged (primary v AND 0xFFC0), which equals 0x2000 OR (last primary write word AND 0xC0FF).
- R10: After reset both bases are 0 and `reg_rdata_o` reads 0x2000.
- R11: During a miss, `win_idx_o` keeps the index of the most recent hit (0 after reset).
- R12: A write takes effect at the clock edge that samples `reg_wr_i`. An access in the same cycle as the write is translated with the old base, and the new base applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dual_en_i | input | 1 | Enables the split into two windows |
| aperture_base_i | input | 32 | Host byte address of the aperture start |
| reg_wr_i | input | 1 | Window register write strobe |
| reg_wdata_i | input | 16 | Window register write data, byte-exchanged |
| reg_rdata_o | output | 16 | Identity bit plus primary window readback |
| acc_valid_i | input | 1 | Host access present |
| acc_addr_i | input | 32 | Host byte address |
| hit_o | output | 1 | Access falls inside the aperture |
| win_idx_o | output | 1 | Window used: 0 primary, 1 secondary |
| pci_addr_o | output | 32 | Translated PCI byte address |

## Verification
A window register write and a translated access can occur in the same cycle. The bench provokes this by driving a primary-base write together with an access into the lower half. It then samples the PCI address twice. Before the edge the address must still carry the old base, and after the edge it must carry the new one. The same collision is also run with the secondary-select bit set while dual mode is off, to confirm that the write is steered to the primary base.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam logic [15:0] ID_WORD = 16'h2000;

  function automatic logic [15:0] swap16(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction
endpackage

// File: rtl/pwx_win_regs.sv
module pwx_win_regs
  import pwx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 6,
  parameter int WIN_SH  = 16,
  parameter int SEL_BIT = 4,
  localparam int FLD_W  = 16 - WIN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_en_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [FLD_W-1:0]  win0_o,
  output logic [FLD_W-1:0]  win1_o,
  output logic [ADDR_W-1:0] base0_o,
  output logic [ADDR_W-1:0] base1_o,
  output logic [15:0]       rdata_o
);
  logic [15:0]      val;
  logic             to_sec;
  logic [FLD_W-1:0] win0_q, win1_q;

  assign val    = swap16(wdata_i);
  assign to_sec = dual_en_i & val[SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win0_q <= '0;
      win1_q <= '0;
    end else if (wr_i) begin
      if (to_sec) win1_q <= val[15:WIN_LSB];
      else        win0_q <= val[15:WIN_LSB];
    end
  end

  assign base0_o = ADDR_W'(win0_q) << (WIN_LSB + WIN_SH);
  assign base1_o = ADDR_W'(win1_q) << (WIN_LSB + WIN_SH);
  assign rdata_o = ID_WORD | swap16({win0_q, {WIN_LSB{1'b0}}});
  assign win0_o  = win0_q;
  assign win1_o  = win1_q;
endmodule

// File: rtl/pwx_addr_decode.sv
module pwx_addr_decode #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 22
) (
  input  logic              dual_en_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ap_base_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  output logic              hit_o,
  output logic              sec_o,
  output logic [ADDR_W-1:0] pci_o
);
  localparam logic [ADDR_W-1:0] APER_SZ = ADDR_W'(1) << (HALF_W + 1);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] half_off;

  // wrap on subtraction makes below-base addresses large, so one compare covers both ends
  assign off      = addr_i - ap_base_i;
  assign half_off = ADDR_W'(off[HALF_W-1:0]);
  assign hit_o    = valid_i && (off < APER_SZ);
  assign sec_o    = dual_en_i & off[HALF_W];
  assign pci_o    = sec_o ? (base1_i + half_off) : (base0_i + off);
endmodule

// File: rtl/pwx_idx_hold.sv
module pwx_idx_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic sec_i,
  output logic idx_o
);
  logic idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= 1'b0;
    else if (hit_i) idx_q <= sec_i;
  end

  assign idx_o = hit_i ? sec_i : idx_q;
endmodule

// File: rtl/pci_window_xlat.sv
module pci_window_xlat #(
  parameter int ADDR_W  = 32,
  parameter int HALF_W  = 22,
  parameter int WIN_LSB = 6,
  parameter int WIN_SH  = 16,
  parameter int SEL_BIT = 4,
  localparam int FLD_W  = 16 - WIN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_en_i,
  input  logic [ADDR_W-1:0] aperture_base_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              hit_o,
  output logic              win_idx_o,
  output logic [ADDR_W-1:0] pci_addr_o
);
  logic [FLD_W-1:0]  win0, win1;
  logic [ADDR_W-1:0] base0, base1;
  logic              sec;

  pwx_win_regs #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .WIN_SH(WIN_SH), .SEL_BIT(SEL_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .dual_en_i(dual_en_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .win0_o(win0), .win1_o(win1), .base0_o(base0), .base1_o(base1),
    .rdata_o(reg_rdata_o)
  );

  pwx_addr_decode #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_dec (
    .dual_en_i(dual_en_i), .valid_i(acc_valid_i), .addr_i(acc_addr_i),
    .ap_base_i(aperture_base_i), .base0_i(base0), .base1_i(base1),
    .hit_o(hit_o), .sec_o(sec), .pci_o(pci_addr_o)
  );

  pwx_idx_hold u_idx (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_o), .sec_i(sec), .idx_o(win_idx_o)
  );
endmodule

// File: rtl/pci_window_xlat_chk.sv
module pci_window_xlat_chk #(
  parameter int FLD_W   = 10,
  parameter int SEL_BIT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dual_en_i,
  input logic             reg_wr_i,
  input logic [15:0]      reg_wdata_i,
  input logic [15:0]      reg_rdata_o,
  input logic             hit_o,
  input logic             win_idx_o,
  input logic [FLD_W-1:0] win0,
  input logic [FLD_W-1:0] win1
);
  localparam int RAW_SEL = (SEL_BIT + 8) % 16;

  p_sec_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && dual_en_i && reg_wdata_i[RAW_SEL] |=> $stable(win0))
    else $error("R3 primary changed on secondary write");

  p_pri_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_wdata_i[RAW_SEL] |=> $stable(win1))
    else $error("R4 secondary changed on primary write");

  p_single_sec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !dual_en_i |=> $stable(win1))
    else $error("R5 secondary changed in single mode");

  p_single_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !dual_en_i |-> !win_idx_o)
    else $error("R5 index 1 in single mode");

  p_id_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[13:8] == 6'h20)
    else $error("R9 readback id field");

  p_miss_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> (hit_o || $stable(win_idx_o)))
    else $error("R11 index moved during miss");

  p_wr_effect_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !(dual_en_i && reg_wdata_i[RAW_SEL])
    |=> reg_rdata_o == (16'h2000 | ($past(reg_wdata_i) & 16'hC0FF)))
    else $error("R12 readback after write");
endmodule

bind pci_window_xlat pci_window_xlat_chk #(.FLD_W(FLD_W), .SEL_BIT(SEL_BIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dual_en_i(dual_en_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .hit_o(hit_o),
  .win_idx_o(win_idx_o), .win0(win0), .win1(win1)
);

// File: tb/tb_pci_window_xlat.sv
module tb_pci_window_xlat;
  localparam logic [31:0] AB = 32'h0060_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] rdata;
  logic        hit, idx;
  logic [31:0] pci;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  pci_window_xlat dut (
    .clk_i(clk), .rst_ni(rst_n), .dual_en_i(dual), .aperture_base_i(AB),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .acc_valid_i(valid), .acc_addr_i(addr),
    .hit_o(hit), .win_idx_o(idx), .pci_addr_o(pci)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // logical value v is sent byte-exchanged
  task automatic write_v(input logic [15:0] v);
    @(negedge clk);
    wr = 1'b1; wdata = {v[7:0], v[15:8]};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic access(input logic [31:0] a);
    @(negedge clk);
    valid = 1'b1; addr = a;
    #1;
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic        h;
    logic        i;
    logic [31:0] p;
  } vec_t;

  // primary base 0x1240_0000, secondary base 0x8040_0000, dual mode
  localparam vec_t VECS [8] = '{
    '{AB,                  1'b1, 1'b0, 32'h1240_0000},
    '{AB + 32'h003F_FFFC,  1'b1, 1'b0, 32'h127F_FFFC},
    '{AB + 32'h0040_0000,  1'b1, 1'b1, 32'h8040_0000},
    '{AB + 32'h007F_FFFF,  1'b1, 1'b1, 32'h807F_FFFF},
    '{AB + 32'h0080_0000,  1'b0, 1'b1, 32'h0},
    '{AB - 32'h1,          1'b0, 1'b1, 32'h0},
    '{AB + 32'h0012_3456,  1'b1, 1'b0, 32'h1252_3456},
    '{32'h0,               1'b0, 1'b0, 32'h0}
  };

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 rdata", 32'(rdata), 32'h2000);
    dual = 1'b1;
    access(AB + 32'h10);
    check("R10 primary zero", pci, 32'h10);
    access(AB + 32'h0040_0020);
    check("R10 secondary zero", pci, 32'h20);
    check("R11 idx before miss", 32'(idx), 32'h1);
    access(AB + 32'h0100_0000);
    check("R11 hold", 32'(idx), 32'h1);
    check("R6 miss", 32'(hit), 32'h0);
    valid = 1'b0;

    // R1 R2 R4: v=0x126F, bit4 clear, masked 0x1240
    write_v(16'h126F);
    #1;
    check("R1 R9 readback", 32'(rdata), 32'h6012);
    // R3: v=0x8050 bit4 set -> secondary 0x8040
    write_v(16'h8050);
    #1;
    check("R3 readback unchanged", 32'(rdata), 32'h6012);

    foreach (VECS[k]) begin
      access(VECS[k].a);
      check($sformatf("R6 hit vec%0d", k), 32'(hit), 32'(VECS[k].h));
      check($sformatf("R7 R11 idx vec%0d", k), 32'(idx), 32'(VECS[k].i));
      if (VECS[k].h)
        check($sformatf("R2 R7 R8 pci vec%0d", k), pci, VECS[k].p);
    end

    // R5 single mode
    dual = 1'b0;
    access(AB + 32'h0040_0000);
    check("R5 idx", 32'(idx), 32'h0);
    check("R8 single pci", pci, 32'h1280_0000);
    valid = 1'b0;
    write_v(16'h2010);
    #1;
    check("R5 goes primary", 32'(rdata), 32'h2020);
    dual = 1'b1;
    access(AB + 32'h0040_0004);
    check("R5 secondary untouched", pci, 32'h8040_0004);

    // R12 write and access in same cycle
    @(negedge clk);
    valid = 1'b1; addr = AB + 32'h10;
    wr = 1'b1; wdata = 16'h0030;
    #1;
    check("R12 old base", pci, 32'h2000_0010);
    @(negedge clk);
    wr = 1'b0;
    #1;
    check("R12 new base", pci, 32'h3000_0010);
    check("R12 readback", 32'(rdata), 32'h2030);

    // collision with select bit in single mode
    dual = 1'b0;
    @(negedge clk);
    wr = 1'b1; wdata = {8'h10, 8'h44};
    #1;
    check("R12 old base single", pci, 32'h3000_0010);
    @(negedge clk);
    wr = 1'b0;
    #1;
    check("R5 R12 single new", pci, 32'h4400_0010);
    dual = 1'b1;
    addr = AB + 32'h0040_0000;
    #1;
    check("R5 secondary kept", pci, 32'h8040_0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule